// File: doc/BRIEF.md
# Stride Prefetcher with Stream Buffer

This engine sits next to a data cache and watches the block addresses of demand misses. From those misses it predicts a future block and requests it from memory. No software takes part. In next-line mode every miss on block X predicts block X+1. In stride mode the engine learns a fixed distance between successive miss blocks and predicts the missed block plus that distance.

Predicted blocks are not written into the cache. They wait in a small fully associative stream buffer, so a wrong guess cannot evict a useful cache line. Each buffer entry records a block address and whether its fill data has come back from memory yet. The cache looks up its demand accesses in the buffer. A hit on a filled entry sends that block to the cache for installation and frees the entry.

Top module: `stride_pf_sbuf`

## Requirements
- R1: With `mode_stride` low, a miss on block X raises `pf_req_valid` on the next cycle with `pf_req_blk` = X+1, unless R5 suppresses it.
- R2: With `mode_stride` high, a miss on block B whose distance from the previous miss block equals the stored distance D, with D nonzero, raises `pf_req_valid` on the next cycle with `pf_req_blk` = B+D. The distance is modular over the block width.
- R3: In stride mode, a miss whose distance differs from the stored distance issues no request. The new distance replaces the stored one. The miss history is updated in both modes.
- R4: A distance of zero never issues a request, even when it repeats.
- R5: No request is issued for a block that already sits in the buffer, whether its fill is pending or done.
- R6: The buffer holds 4 entries. Each issued request allocates one entry in FIFO order. The fifth allocation overwrites the oldest entry, so that block may be requested again.
- R7: `lk_hit` is combinational. It is high only for a valid entry whose fill has returned. A lookup in the same cycle as the matching fill still misses, and the next cycle hits.
- R8: A lookup hit raises `promo_valid` on the next cycle with `promo_blk` equal to the looked-up block. The entry is invalidated at that edge, and later lookups of that block miss.
- R9: Reset clears the outputs, empties the buffer and clears the stride history. After reset, the first two stride-mode misses issue nothing.
- R10: A fill for a block that is not pending in the buffer changes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_stride | input | 1 | 0 selects next-line prediction, 1 selects stride prediction |
| miss_valid | input | 1 | A demand miss is observed this cycle |
| miss_blk | input | BLK_W | Block address of the demand miss |
| pf_req_valid | output | 1 | Prefetch request to memory |
| pf_req_blk | output | BLK_W | Block address requested |
| fill_valid | input | 1 | Memory returns a prefetched block |
| fill_blk | input | BLK_W | Block address of the returned fill |
| lk_valid | input | 1 | The cache looks up a demand block in the buffer |
| lk_blk | input | BLK_W | Block address looked up |
| lk_hit | output | 1 | The lookup matched a filled entry |
| promo_valid | output | 1 | Block is handed to the cache for installation |
| promo_blk | output | BLK_W | Block address handed to the cache |

## Verification
A returning fill and a demand lookup of the same block can arrive in the same cycle. The bench drives both on one cycle for a pending entry. It expects `lk_hit` low in that cycle and high on the next. It then checks that the promotion appears one cycle later and that a repeat lookup misses. A second overlap, a new allocation while older entries are still pending, is exercised when the FIFO wraps. There the bench judges the result by re-requesting the evicted block.

// File: rtl/stride_pf_sbuf.sv
module stride_pf_sbuf #(
  parameter int BLK_W = 32,
  parameter int DEPTH = 4,
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_stride,
  input  logic             miss_valid,
  input  logic [BLK_W-1:0] miss_blk,
  output logic             pf_req_valid,
  output logic [BLK_W-1:0] pf_req_blk,
  input  logic             fill_valid,
  input  logic [BLK_W-1:0] fill_blk,
  input  logic             lk_valid,
  input  logic [BLK_W-1:0] lk_blk,
  output logic             lk_hit,
  output logic             promo_valid,
  output logic [BLK_W-1:0] promo_blk
);

  logic [DEPTH-1:0] e_vld, e_pend;
  logic [BLK_W-1:0] e_blk [DEPTH];
  logic [PW-1:0]    wr_ptr;
  logic [BLK_W-1:0] last_blk, last_str;
  logic             have_last, have_str;

  logic [DEPTH-1:0] cand_vec, look_vec, fill_vec;

  wire [BLK_W-1:0] cur_str   = miss_blk - last_blk;
  wire             stride_ok = have_last && have_str && (cur_str == last_str) && (|cur_str);
  wire [BLK_W-1:0] cand      = mode_stride ? miss_blk + cur_str : miss_blk + 1'b1;
  wire             issue     = miss_valid && (mode_stride ? stride_ok : 1'b1) && !(|cand_vec);

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    assign cand_vec[i] = e_vld[i] && (e_blk[i] == cand);
    assign look_vec[i] = lk_valid && e_vld[i] && !e_pend[i] && (e_blk[i] == lk_blk);
    assign fill_vec[i] = fill_valid && e_vld[i] && e_pend[i] && (e_blk[i] == fill_blk);
  end

  assign lk_hit = |look_vec;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pf_req_valid <= 1'b0;
      pf_req_blk   <= '0;
      promo_valid  <= 1'b0;
      promo_blk    <= '0;
      e_vld        <= '0;
      e_pend       <= '0;
      wr_ptr       <= '0;
      last_blk     <= '0;
      last_str     <= '0;
      have_last    <= 1'b0;
      have_str     <= 1'b0;
      for (int i = 0; i < DEPTH; i++) e_blk[i] <= '0;
    end else begin
      pf_req_valid <= issue;
      if (issue) pf_req_blk <= cand;
      promo_valid <= lk_hit;
      if (lk_hit) promo_blk <= lk_blk;

      if (miss_valid) begin
        last_blk  <= miss_blk;
        have_last <= 1'b1;
        if (have_last) begin
          last_str <= cur_str;
          have_str <= 1'b1;
        end
      end

      for (int i = 0; i < DEPTH; i++) begin
        if (fill_vec[i]) e_pend[i] <= 1'b0;
        if (look_vec[i]) e_vld[i]  <= 1'b0;
      end

      if (issue) begin
        e_vld[wr_ptr]  <= 1'b1;
        e_pend[wr_ptr] <= 1'b1;
        e_blk[wr_ptr]  <= cand;
        wr_ptr <= (wr_ptr == PW'(DEPTH-1)) ? '0 : wr_ptr + 1'b1;
      end
    end
  end

endmodule

// File: rtl/stride_pf_sbuf_chk.sv
module stride_pf_sbuf_chk #(
  parameter int BLK_W = 32,
  parameter int DEPTH = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             mode_stride,
  input logic             miss_valid,
  input logic [BLK_W-1:0] miss_blk,
  input logic             pf_req_valid,
  input logic [BLK_W-1:0] pf_req_blk,
  input logic             lk_valid,
  input logic [BLK_W-1:0] lk_blk,
  input logic             lk_hit,
  input logic             promo_valid,
  input logic [BLK_W-1:0] promo_blk,
  input logic [DEPTH-1:0] look_vec
);

  AST_REQ_NEEDS_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    pf_req_valid |-> $past(miss_valid)); // R2

  AST_NEXT_LINE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    (pf_req_valid && !$past(mode_stride)) |-> pf_req_blk == $past(miss_blk) + 1'b1); // R1

  AST_STRIDE_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (pf_req_valid && $past(mode_stride)) |-> pf_req_blk != $past(miss_blk)); // R4

  AST_NO_REPEAT_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (pf_req_valid && $past(pf_req_valid)) |-> pf_req_blk != $past(pf_req_blk)); // R5

  AST_UNIQUE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(look_vec)); // R5

  AST_PROMO_FROM_LOOKUP: assert property (@(posedge clk) disable iff (!rst_n)
    promo_valid |-> ($past(lk_valid) && promo_blk == $past(lk_blk))); // R8

  AST_PROMO_FREES_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    promo_valid |-> !(lk_hit && lk_blk == promo_blk)); // R8

endmodule

bind stride_pf_sbuf stride_pf_sbuf_chk #(.BLK_W(BLK_W), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode_stride(mode_stride), .miss_valid(miss_valid),
  .miss_blk(miss_blk), .pf_req_valid(pf_req_valid), .pf_req_blk(pf_req_blk),
  .lk_valid(lk_valid), .lk_blk(lk_blk), .lk_hit(lk_hit), .promo_valid(promo_valid),
  .promo_blk(promo_blk), .look_vec(look_vec)
);

// File: tb/sim_stride_pf_sbuf.sv
module sim_stride_pf_sbuf;
  localparam int W = 32;

  logic clk = 1'b0, rst_n = 1'b0;
  logic mode_stride = 1'b0, miss_valid = 1'b0, fill_valid = 1'b0, lk_valid = 1'b0;
  logic [W-1:0] miss_blk = '0, fill_blk = '0, lk_blk = '0;
  logic pf_req_valid, lk_hit, promo_valid;
  logic [W-1:0] pf_req_blk, promo_blk;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  stride_pf_sbuf u0 (
    .clk(clk), .rst_n(rst_n), .mode_stride(mode_stride), .miss_valid(miss_valid),
    .miss_blk(miss_blk), .pf_req_valid(pf_req_valid), .pf_req_blk(pf_req_blk),
    .fill_valid(fill_valid), .fill_blk(fill_blk), .lk_valid(lk_valid), .lk_blk(lk_blk),
    .lk_hit(lk_hit), .promo_valid(promo_valid), .promo_blk(promo_blk)
  );

  // {mode, miss block, expect request, expected block}
  localparam logic [65:0] VEC [12] = '{
    {1'b0, 32'd100,  1'b1, 32'd101 },  // R1
    {1'b0, 32'd200,  1'b1, 32'd201 },  // R1
    {1'b0, 32'd100,  1'b0, 32'd0   },  // R5 101 present
    {1'b1, 32'd1000, 1'b0, 32'd0   },  // R3
    {1'b1, 32'd1004, 1'b0, 32'd0   },  // R3
    {1'b1, 32'd1008, 1'b1, 32'd1012},  // R2
    {1'b1, 32'd1012, 1'b1, 32'd1016},  // R2
    {1'b1, 32'd1012, 1'b0, 32'd0   },  // R4
    {1'b1, 32'd1012, 1'b0, 32'd0   },  // R4 zero repeated
    {1'b1, 32'd1009, 1'b0, 32'd0   },  // R3
    {1'b1, 32'd1006, 1'b1, 32'd1003},  // R2 negative, R6 wraps
    {1'b0, 32'd100,  1'b1, 32'd101 }   // R6 evicted block requested again
  };

  task automatic chk(input bit ok, input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic miss_step(input logic m, input logic [W-1:0] b, input logic ev,
                           input logic [W-1:0] eb, input string req);
    @(negedge clk);
    mode_stride = m; miss_valid = 1'b1; miss_blk = b;
    @(negedge clk);
    miss_valid = 1'b0;
    chk(pf_req_valid == ev, req, W'(pf_req_valid), W'(ev));
    if (ev) chk(pf_req_blk == eb, req, pf_req_blk, eb);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!pf_req_valid && !promo_valid && !lk_hit, "R9", W'(pf_req_valid), 0);
    rst_n = 1'b1;

    foreach (VEC[i])
      miss_step(VEC[i][65], VEC[i][64:33], VEC[i][32], VEC[i][31:0], $sformatf("R1/R2 row%0d", i));

    // R7: pending entry does not hit
    @(negedge clk);
    lk_valid = 1'b1; lk_blk = 32'd1012; #1;
    chk(!lk_hit, "R7 pending", W'(lk_hit), 0);
    // R7: fill and lookup in the same cycle
    @(negedge clk);
    fill_valid = 1'b1; fill_blk = 32'd1012; #1;
    chk(!lk_hit, "R7 same-cycle", W'(lk_hit), 0);
    @(negedge clk);
    fill_valid = 1'b0; #1;
    chk(lk_hit, "R7 after fill", W'(lk_hit), 1);
    @(negedge clk); #1;
    chk(promo_valid && promo_blk == 32'd1012, "R8 promote", promo_blk, 32'd1012);
    chk(!lk_hit, "R8 freed", W'(lk_hit), 0);
    lk_valid = 1'b0;

    // R10: stray fill ignored
    @(negedge clk);
    fill_valid = 1'b1; fill_blk = 32'd7777;
    @(negedge clk);
    fill_valid = 1'b0; lk_valid = 1'b1; lk_blk = 32'd7777; #1;
    chk(!lk_hit, "R10 stray", W'(lk_hit), 0);
    lk_blk = 32'd1016; #1;
    chk(!lk_hit, "R10 other pending", W'(lk_hit), 0);
    lk_valid = 1'b0;

    // R9: reset empties buffer and history
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    chk(!pf_req_valid && !promo_valid, "R9 outputs", W'(pf_req_valid), 0);
    fill_valid = 1'b1; fill_blk = 32'd1016;
    @(negedge clk);
    fill_valid = 1'b0; lk_valid = 1'b1; lk_blk = 32'd1016; #1;
    chk(!lk_hit, "R9 buffer empty", W'(lk_hit), 0);
    lk_valid = 1'b0;
    miss_step(1'b1, 32'd10, 1'b0, 0, "R9 first");
    miss_step(1'b1, 32'd14, 1'b0, 0, "R9 second");
    miss_step(1'b1, 32'd18, 1'b1, 32'd22, "R9 third R2");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule